// File: doc/BRIEF.md
# Reduced-Pin Transmit Dibit-to-Nibble Adapter

This block sits between a MAC's transmit port and a 100 Mb/s line encoder. In reduced-pin mode the MAC sends 2-bit dibits on a 50 MHz reference clock, each qualified by a transmit enable. The adapter groups consecutive dibits into 4-bit nibbles and marks each finished nibble with a one-cycle valid flag. The valid flag is raised on every second clock, which gives the 25 MHz nibble rate the encoder needs. Pairing restarts at each frame, so every frame begins on a nibble boundary.

A mode input switches the block to a plain 4-bit pass-through. In that mode the clock port carries the 25 MHz transmit clock and each enabled 4-bit word is forwarded as one nibble. The mode may only change while the enable is low. Clock selection and generation are done outside the block.

When a reduced-pin frame ends with an unpaired dibit, the half nibble is dropped and a one-cycle alignment-error pulse is raised.

Top module: `tx_pair_adapter`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, `nibValid` and `alignErr` are 0 and `nibOut` is 0.
- R2: In reduced-pin mode (`modeMii`=0), the first dibit of a pair (`txData[1:0]`) becomes `nibOut[1:0]` and the second becomes `nibOut[3:2]`. The nibble appears with `nibValid`=1 two clock edges after the edge that captured the second dibit.
- R3: In reduced-pin mode, `nibValid` is never high on two consecutive clocks.
- R4: Each rising edge of `txEn` starts a new pair. A frame that follows an odd-length frame is still paired from its first dibit.
- R5: If `txEn` falls after an odd number of dibits, the unpaired dibit is discarded with no `nibValid`. `alignErr` is then high for exactly one clock, two edges after `txEn` is captured low. It is never high together with `nibValid`.
- R6: In pass-through mode (`modeMii`=1), every clock whose captured `txEn` is 1 produces `nibOut` equal to that `txData`, with `nibValid`=1, two edges later.
- R7: `txData` captured while `txEn` is 0 produces no `nibValid` and does not alter any later nibble.
- R8: `modeMii` is held stable while `txEn` stays high. Changing it during an idle gap of at least two clocks gives clean operation in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock in reduced-pin mode, 25 MHz transmit clock in pass-through mode |
| rstN | input | 1 | Asynchronous active-low reset |
| modeMii | input | 1 | 0 = 2-bit reduced-pin input, 1 = 4-bit pass-through |
| txEn | input | 1 | Transmit enable from the MAC |
| txData | input | 4 | Transmit data; only bits [1:0] are used in reduced-pin mode |
| nibOut | output | 4 | Nibble toward the encoder |
| nibValid | output | 1 | `nibOut` holds a new nibble this clock |
| alignErr | output | 1 | One-clock pulse: a frame ended on a half nibble |

## Verification
A stuck or inverted pairing phase shows at the ports within one frame: nibbles come out with their halves swapped, valid pulses fall on the wrong clocks, or the error pulse is missing or spurious. A phase that fails to clear between frames only shows after an odd-length frame. For that reason the stimulus places an odd frame directly before an even one and compares every nibble in order. A wrong captured mode corrupts the first nibble after the switch, so the mode changes in an idle gap and the next frame is checked at once.

// File: rtl/tx_pair_pkg.sv
package tx_pair_pkg;
  parameter int DIBIT_W  = 2;
  localparam int NIBBLE_W = 2 * DIBIT_W;

  // strobes from control to datapath, valid for the current capture stage
  typedef struct packed {
    logic loadLow;   // hold captured dibit as low half
    logic emitPair;  // emit {captured dibit, low half}
    logic emitWide;  // emit captured word directly
    logic flagErr;   // frame closed on half nibble
  } ctrlStrobe_t;
endpackage

// File: rtl/tx_pair_ctrl.sv
module tx_pair_ctrl
  import tx_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enQ,
  input  logic        modeQ,
  output ctrlStrobe_t strobe
);
  logic phaseHigh;
  logic phaseNext;

  always_comb begin
    strobe    = '0;
    phaseNext = 1'b0;
    if (modeQ) begin
      strobe.emitWide = enQ;
    end else if (enQ) begin
      if (phaseHigh) begin
        strobe.emitPair = 1'b1;
      end else begin
        strobe.loadLow = 1'b1;
        phaseNext      = 1'b1;
      end
    end else if (phaseHigh) begin
      // enable dropped while waiting for the upper half
      strobe.flagErr = 1'b1;
    end
  end

  // phase clears whenever enable is low, so every frame starts aligned
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseHigh <= 1'b0;
    else       phaseHigh <= phaseNext;
  end
endmodule

// File: rtl/tx_pair_dp.sv
module tx_pair_dp
  import tx_pair_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeIn,
  input  logic                enIn,
  input  logic [NIBBLE_W-1:0] dataIn,
  input  ctrlStrobe_t         strobe,
  output logic                enQ,
  output logic                modeQ,
  output logic [NIBBLE_W-1:0] nibOut,
  output logic                nibValid,
  output logic                alignErr
);
  logic [NIBBLE_W-1:0] dataQ;
  logic [DIBIT_W-1:0]  lowHalf;
  logic [NIBBLE_W-1:0] nibNext;

  // capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      modeQ <= 1'b0;
      dataQ <= '0;
    end else begin
      enQ   <= enIn;
      modeQ <= modeIn;
      dataQ <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowHalf <= '0;
    else if (strobe.loadLow) lowHalf <= dataQ[DIBIT_W-1:0];
  end

  always_comb begin
    if (strobe.emitWide) nibNext = dataQ;
    else                 nibNext = {dataQ[DIBIT_W-1:0], lowHalf};
  end

  // output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibOut   <= '0;
      nibValid <= 1'b0;
      alignErr <= 1'b0;
    end else begin
      nibValid <= strobe.emitPair | strobe.emitWide;
      alignErr <= strobe.flagErr;
      if (strobe.emitPair | strobe.emitWide) nibOut <= nibNext;
    end
  end
endmodule

// File: rtl/tx_pair_adapter.sv
module tx_pair_adapter
  import tx_pair_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeMii,
  input  logic                txEn,
  input  logic [NIBBLE_W-1:0] txData,
  output logic [NIBBLE_W-1:0] nibOut,
  output logic                nibValid,
  output logic                alignErr
);
  ctrlStrobe_t strobe;
  logic        enQ;
  logic        modeQ;

  tx_pair_dp u_dp (
    .clk(clk), .rstN(rstN), .modeIn(modeMii), .enIn(txEn), .dataIn(txData),
    .strobe(strobe), .enQ(enQ), .modeQ(modeQ),
    .nibOut(nibOut), .nibValid(nibValid), .alignErr(alignErr)
  );

  tx_pair_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enQ(enQ), .modeQ(modeQ), .strobe(strobe)
  );
endmodule

// File: rtl/tx_pair_checker.sv
module tx_pair_checker
  import tx_pair_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                modeMii,
  input logic                txEn,
  input logic [NIBBLE_W-1:0] txData,
  input logic [NIBBLE_W-1:0] nibOut,
  input logic                nibValid,
  input logic                alignErr
);
  // R1: outputs quiet while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!nibValid && !alignErr && nibOut == '0)
        else $error("R1 outputs active in reset");
    end
  end

  p_no_back2back_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeMii && !$past(modeMii) && !$past(modeMii, 2) && !$past(modeMii, 3) && $past(nibValid))
      |-> !nibValid);

  p_err_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(nibValid && alignErr));

  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> !alignErr);

  p_err_after_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> !$past(txEn, 2));

  p_pass_through_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeMii, 2) && $past(txEn, 2))
      |-> (nibValid && nibOut == $past(txData, 2)));

  p_valid_needs_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    nibValid |-> $past(txEn, 2));

  p_mode_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && $past(txEn)) |-> $stable(modeMii));
endmodule

bind tx_pair_adapter tx_pair_checker u_chk (
  .clk(clk), .rstN(rstN), .modeMii(modeMii), .txEn(txEn), .txData(txData),
  .nibOut(nibOut), .nibValid(nibValid), .alignErr(alignErr)
);

// File: tb/tx_pair_adapter_bench.sv
module tx_pair_adapter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeMii = 1'b0;
  logic       txEn = 1'b0;
  logic [3:0] txData = '0;
  logic [3:0] nibOut;
  logic       nibValid;
  logic       alignErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed { logic isErr; logic [3:0] nib; } item_t;
  item_t expQ[$];

  always #2 clk = ~clk;

  tx_pair_adapter u_tx_pair_adapter (
    .clk(clk), .rstN(rstN), .modeMii(modeMii), .txEn(txEn), .txData(txData),
    .nibOut(nibOut), .nibValid(nibValid), .alignErr(alignErr)
  );

  task automatic drive(input logic en, input logic [3:0] d);
    @(posedge clk); #1;
    txEn = en; txData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 4'hF);
  endtask

  // reduced-pin frame: nibbles split low dibit first; optional trailing odd dibit
  task automatic rmiiFrame(input logic [3:0] nibs[], input bit oddTail, input logic [1:0] tail);
    foreach (nibs[i]) begin
      expQ.push_back('{isErr: 1'b0, nib: nibs[i]});
      drive(1'b1, {2'b11, nibs[i][1:0]});  // upper bits ignored (R2)
      drive(1'b1, {2'b00, nibs[i][3:2]});
    end
    if (oddTail) begin
      expQ.push_back('{isErr: 1'b1, nib: 4'h0});
      drive(1'b1, {2'b10, tail});
    end
    drive(1'b0, 4'h5);
  endtask

  task automatic miiFrame(input logic [3:0] nibs[]);
    foreach (nibs[i]) begin
      expQ.push_back('{isErr: 1'b0, nib: nibs[i]});
      drive(1'b1, nibs[i]);
    end
    drive(1'b0, 4'hA);
  endtask

  // monitor / scoreboard
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (nibValid && prevValid && !modeMii) begin
        checks++; fails++;
        $display("FAIL R3: valid on consecutive clocks, actual 1 expected 0");
      end
      if (nibValid || alignErr) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R7/R5: unexpected output valid=%0b err=%0b nib=%h, expected none",
                   nibValid, alignErr, nibOut);
        end else begin
          item_t e;
          e = expQ.pop_front();
          if (e.isErr) begin
            if (!alignErr || nibValid) begin
              fails++;
              $display("FAIL R5: actual valid=%0b err=%0b, expected valid=0 err=1",
                       nibValid, alignErr);
            end
          end else if (!nibValid || alignErr || nibOut !== e.nib) begin
            fails++;
            $display("FAIL R2/R4/R6: actual valid=%0b err=%0b nib=%h, expected nib=%h",
                     nibValid, alignErr, nibOut, e.nib);
          end
        end
      end
      prevValid = nibValid;
    end
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    checks++;
    if (nibValid !== 1'b0 || alignErr !== 1'b0 || nibOut !== 4'h0) begin
      fails++;
      $display("FAIL R1: actual valid=%0b err=%0b nib=%h, expected 0 0 0", nibValid, alignErr, nibOut);
    end
    rstN = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (nibValid !== 1'b0 || alignErr !== 1'b0) begin
      fails++;
      $display("FAIL R1: after release valid=%0b err=%0b, expected 0 0", nibValid, alignErr);
    end

    // R7: noise with enable low
    for (int i = 0; i < 6; i++) drive(1'b0, i[3:0]);
    idle(2);
    // R2: basic pairing
    rmiiFrame('{4'h1, 4'hE, 4'h6, 4'h9}, 1'b0, 2'b00);
    idle(2);
    // R5: odd tail then R4: next frame aligned
    rmiiFrame('{4'h3, 4'hC}, 1'b1, 2'b01);
    rmiiFrame('{4'h7, 4'h8, 4'h2}, 1'b0, 2'b00);
    idle(3);
    // R5: single-dibit frame
    rmiiFrame('{}, 1'b1, 2'b11);
    idle(1);
    rmiiFrame('{4'h5, 4'hA, 4'hF, 4'h0, 4'hB}, 1'b0, 2'b00);
    idle(3);
    // R8: mode change in idle gap, R6 pass-through
    drive(1'b0, 4'h0); modeMii = 1'b1;
    idle(3);
    miiFrame('{4'h4, 4'hD, 4'h1, 4'h2, 4'hE});
    idle(2);
    miiFrame('{4'h9});
    idle(3);
    drive(1'b0, 4'h0); modeMii = 1'b0;
    idle(3);
    rmiiFrame('{4'h6, 4'hC}, 1'b1, 2'b10);
    idle(6);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2/R5/R6: actual %0d items outstanding, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule